// File: doc/BRIEF.md
# Fat-Tree Routing and Acknowledge Element

This block makes the routing decision for one switch element of a fat-tree network. The element has `RADIX` down ports (numbered 0 to RADIX-1) that face the leaves and `RADIX` up ports (numbered RADIX to 2*RADIX-1) that face the root. Each packet header that arrives is classified as unicast or broadcast. The element then sends it down toward the destination, or up toward the root when the destination lies outside its subtree. When a packet goes up, the element chooses the up link that has the fewest unacknowledged packets and skips any link that is disabled. When a broadcast range lies entirely under the element, the header is copied to every down port that covers part of that range.

The element stores each forwarded packet in a return-path table indexed by the packet tag. An entry holds the input port, a mask of output ports still owing an acknowledge, and a sticky failure flag. Acknowledges come back one per cycle on a single channel that carries the port number, the tag and a success bit. Once every copy has answered, the element sends one combined acknowledge to the recorded input port and frees the entry. The combined acknowledge reports success only if every copy succeeded.

The element sits at tree level `LVL`. A destination address is made of `LEVELS` base-RADIX digits, with digit 0 in the least significant position. The element owns the subtree whose digits above position `LVL` equal those of `PREFIX`. Digit `LVL` of the destination selects the down port. The header controller is a three-state machine:
- S_IDLE: accepts a header.
- S_FWD: presents the forward mask for one cycle.
- S_REJ: returns a failure acknowledge for one cycle.

Its transitions are:
- S_IDLE→S_FWD when a header that can be routed is accepted.
- S_IDLE→S_REJ when a header that must go up finds no enabled up link.
- S_FWD→S_IDLE and S_REJ→S_IDLE unconditionally.

Top module: `fat_tree_router`

## Requirements
- R1: A unicast header whose destination lies in the element's subtree is forwarded, in the cycle after acceptance, with `out_mask` holding only the bit of down port `digit LVL of hdr_dest`.
- R2: A unicast header whose destination lies outside the subtree is forwarded to exactly one up port; `out_mask` bit RADIX+k means up link k.
- R3: The chosen up link is the enabled one with the smallest count of outstanding packets, with ties going to the lowest index. The count rises when a header is forwarded to that link and falls when an accepted acknowledge returns on it.
- R4: A disabled up link (`up_en[k]`=0) is never chosen.
- R5: If a header must go up and no up link is enabled, nothing is forwarded. In the cycle after acceptance, `cack_vld`=1 with `cack_ok`=0, the header's tag, and `cack_port` equal to the input port.
- R6: A broadcast whose `hdr_lo` and `hdr_hi` both lie in the subtree is sent to every down port from digit LVL of `hdr_lo` through digit LVL of `hdr_hi`. Otherwise it goes to one up port, chosen as in R3/R4. The sender must keep `hdr_lo` ≤ `hdr_hi`.
- R7: The combined acknowledge appears in the cycle after the last pending acknowledge of a tag is accepted. It carries the recorded input port and the tag, and `cack_ok`=1 only if every copy reported success. It also frees the tag.
- R8: An acknowledge on a port that is not pending for its tag, or for a tag with no entry, changes nothing and produces no combined acknowledge.
- R9: `hdr_rdy` is 0 while the controller is outside S_IDLE, while `ack_vld`=1, or while the tag on `hdr_tag` has a live entry.
- R10: After reset, `hdr_rdy`=1 (with no acknowledge pending), `out_vld`=0 and `cack_vld`=0, and every up-link load is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hdr_vld | input | 1 | Header present |
| hdr_rdy | output | 1 | Header accepted this cycle when high with hdr_vld |
| hdr_port | input | PORT_W | Port the header arrived on |
| hdr_dest | input | ADDR_W | Unicast destination |
| hdr_lo | input | ADDR_W | Broadcast range low end |
| hdr_hi | input | ADDR_W | Broadcast range high end |
| hdr_bcast | input | 1 | 1 = broadcast, 0 = unicast |
| hdr_tag | input | TAG_W | Packet tag |
| up_en | input | RADIX | Up link enables |
| out_vld | output | 1 | Forward decision valid |
| out_mask | output | 2*RADIX | Output ports; low half down, high half up |
| out_tag | output | TAG_W | Tag of the forwarded header |
| ack_vld | input | 1 | Acknowledge arriving |
| ack_port | input | PORT_W | Port the acknowledge arrived on |
| ack_tag | input | TAG_W | Tag of the acknowledge |
| ack_ok | input | 1 | Acknowledge reports success |
| cack_vld | output | 1 | Combined acknowledge valid |
| cack_port | output | PORT_W | Port to send the combined acknowledge out of |
| cack_ok | output | 1 | Combined success |
| cack_tag | output | TAG_W | Tag of the combined acknowledge |

## Verification
A table of headers exercises the routing function with four kinds of input:
- Unicast destinations inside the subtree, which tell apart the down-port digits.
- Unicast destinations outside the subtree, which show the up-versus-down decision and the effect of the enable mask.
- Broadcast ranges that cover the full subtree, part of it, or stray outside it, which separate range copying from climbing.
- Headers with every up link disabled, which must come back as failures.

A run of up-bound headers with staggered acknowledges builds unequal loads. This tells least-loaded selection apart from fixed-order selection and confirms the lowest-index tie break. Broadcasts with one failing copy, stray acknowledges and duplicate acknowledges separate the merge from a simple pass-through.

// File: rtl/ft_route_pkg.sv
`timescale 1ns/1ps
package ft_route_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_FWD  = 2'd1,
        S_REJ  = 2'd2
    } rt_state_e;
endpackage

// File: rtl/ft_route_decide.sv
`timescale 1ns/1ps
// Up/down decision and down-port mask for one header (combinational).
module ft_route_decide #(
    parameter int unsigned RADIX  = 4,
    parameter int unsigned LEVELS = 3,
    parameter int unsigned LVL    = 1,
    parameter int unsigned DIG_W  = $clog2(RADIX),
    parameter int unsigned ADDR_W = LEVELS * DIG_W,
    parameter logic [ADDR_W-1:0] PREFIX = '0
) (
    input  logic [ADDR_W-1:0] dest,
    input  logic [ADDR_W-1:0] lo,
    input  logic [ADDR_W-1:0] hi,
    input  logic              bcast,
    output logic              go_up,
    output logic [RADIX-1:0]  dn_mask
);
    localparam int unsigned LOW_W = (LVL + 1) * DIG_W;
    localparam logic [ADDR_W-1:0] HI_MASK = ~(ADDR_W'((64'd1 << LOW_W) - 64'd1));

    function automatic logic in_sub(input logic [ADDR_W-1:0] a);
        return ((a ^ PREFIX) & HI_MASK) == '0;
    endfunction

    function automatic logic [DIG_W-1:0] digit(input logic [ADDR_W-1:0] a);
        return a[LVL*DIG_W +: DIG_W];
    endfunction

    logic [DIG_W-1:0] d_lo, d_hi, d_dst;

    always_comb begin
        d_lo    = digit(lo);
        d_hi    = digit(hi);
        d_dst   = digit(dest);
        dn_mask = '0;
        if (bcast) begin
            go_up = !(in_sub(lo) && in_sub(hi));
            if (!go_up) begin
                for (int p = 0; p < int'(RADIX); p++) begin
                    if (DIG_W'(p) >= d_lo && DIG_W'(p) <= d_hi)
                        dn_mask[p] = 1'b1;
                end
            end
        end else begin
            go_up = !in_sub(dest);
            if (!go_up)
                dn_mask[d_dst] = 1'b1;
        end
    end
endmodule

// File: rtl/ft_up_select.sv
`timescale 1ns/1ps
// Per-up-link outstanding counters and least-loaded enabled link choice.
module ft_up_select #(
    parameter int unsigned RADIX = 4,
    parameter int unsigned CNT_W = 4,
    parameter int unsigned DIG_W = $clog2(RADIX)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [RADIX-1:0] up_en,
    input  logic             inc,
    input  logic [DIG_W-1:0] inc_idx,
    input  logic             dec,
    input  logic [DIG_W-1:0] dec_idx,
    output logic [DIG_W-1:0] sel,
    output logic             any_en
);
    logic [CNT_W-1:0] cnt [RADIX];

    genvar g;
    generate
        for (g = 0; g < int'(RADIX); g++) begin : g_cnt
            logic inc_g, dec_g;
            assign inc_g = inc && (inc_idx == DIG_W'(g));
            assign dec_g = dec && (dec_idx == DIG_W'(g));

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    cnt[g] <= '0;
                else
                    cnt[g] <= cnt[g] + CNT_W'(inc_g) - CNT_W'(dec_g);
            end

            // R3: an acknowledge never returns on a link with nothing outstanding
            assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
                dec_g |-> (cnt[g] != '0));
        end
    endgenerate

    logic [CNT_W-1:0] best;
    always_comb begin
        any_en = 1'b0;
        sel    = '0;
        best   = '1;
        for (int i = 0; i < int'(RADIX); i++) begin
            if (up_en[i] && (!any_en || cnt[i] < best)) begin
                any_en = 1'b1;
                sel    = DIG_W'(i);
                best   = cnt[i];
            end
        end
    end

    // R4: chosen link is enabled whenever any is
    assert_up_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        any_en |-> up_en[sel]);
endmodule

// File: rtl/ft_ack_merge.sv
`timescale 1ns/1ps
// Return-path table indexed by tag; merges acknowledges of all copies.
module ft_ack_merge #(
    parameter int unsigned NPORT  = 8,
    parameter int unsigned TAG_W  = 3,
    parameter int unsigned PORT_W = $clog2(NPORT),
    parameter int unsigned DEPTH  = 2 ** TAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc,
    input  logic [TAG_W-1:0]  alloc_tag,
    input  logic [PORT_W-1:0] alloc_port,
    input  logic [NPORT-1:0]  alloc_mask,
    input  logic              ack_vld,
    input  logic [PORT_W-1:0] ack_port,
    input  logic [TAG_W-1:0]  ack_tag,
    input  logic              ack_ok,
    output logic [DEPTH-1:0]  tag_busy,
    output logic              ack_take,
    output logic              cack_vld,
    output logic [PORT_W-1:0] cack_port,
    output logic              cack_ok,
    output logic [TAG_W-1:0]  cack_tag
);
    logic [DEPTH-1:0]  e_vld;
    logic [DEPTH-1:0]  e_fail;
    logic [PORT_W-1:0] e_port [DEPTH];
    logic [NPORT-1:0]  e_pend [DEPTH];

    logic [NPORT-1:0] remain;
    logic             done;

    assign tag_busy = e_vld;
    assign ack_take = ack_vld && e_vld[ack_tag] && e_pend[ack_tag][ack_port];
    assign remain   = e_pend[ack_tag] & ~(NPORT'(1) << ack_port);
    assign done     = ack_take && (remain == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_vld     <= '0;
            e_fail    <= '0;
            cack_vld  <= 1'b0;
            cack_port <= '0;
            cack_ok   <= 1'b0;
            cack_tag  <= '0;
        end else begin
            cack_vld <= done;
            if (done) begin
                cack_port <= e_port[ack_tag];
                cack_ok   <= !e_fail[ack_tag] && ack_ok;
                cack_tag  <= ack_tag;
            end
            if (alloc) begin
                e_vld[alloc_tag]  <= 1'b1;
                e_fail[alloc_tag] <= 1'b0;
                e_port[alloc_tag] <= alloc_port;
                e_pend[alloc_tag] <= alloc_mask;
            end else if (ack_take) begin
                e_pend[ack_tag] <= remain;
                e_fail[ack_tag] <= e_fail[ack_tag] | !ack_ok;
                if (done)
                    e_vld[ack_tag] <= 1'b0;
            end
        end
    end

    // R7: a combined acknowledge leaves its tag free
    assert_free_on_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cack_vld |-> !e_vld[cack_tag]);
    // R9: a live tag is never allocated again
    assert_alloc_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> !e_vld[alloc_tag]);
endmodule

// File: rtl/fat_tree_router.sv
`timescale 1ns/1ps
module fat_tree_router
    import ft_route_pkg::*;
#(
    parameter int unsigned RADIX  = 4,
    parameter int unsigned LEVELS = 3,
    parameter int unsigned LVL    = 1,
    parameter int unsigned TAG_W  = 3,
    parameter int unsigned DIG_W  = $clog2(RADIX),
    parameter int unsigned ADDR_W = LEVELS * DIG_W,
    parameter int unsigned NPORT  = 2 * RADIX,
    parameter int unsigned PORT_W = $clog2(NPORT),
    parameter logic [ADDR_W-1:0] PREFIX = ADDR_W'(32)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hdr_vld,
    output logic              hdr_rdy,
    input  logic [PORT_W-1:0] hdr_port,
    input  logic [ADDR_W-1:0] hdr_dest,
    input  logic [ADDR_W-1:0] hdr_lo,
    input  logic [ADDR_W-1:0] hdr_hi,
    input  logic              hdr_bcast,
    input  logic [TAG_W-1:0]  hdr_tag,
    input  logic [RADIX-1:0]  up_en,
    output logic              out_vld,
    output logic [NPORT-1:0]  out_mask,
    output logic [TAG_W-1:0]  out_tag,
    input  logic              ack_vld,
    input  logic [PORT_W-1:0] ack_port,
    input  logic [TAG_W-1:0]  ack_tag,
    input  logic              ack_ok,
    output logic              cack_vld,
    output logic [PORT_W-1:0] cack_port,
    output logic              cack_ok,
    output logic [TAG_W-1:0]  cack_tag
);
    localparam int unsigned CNT_W = TAG_W + 1;
    localparam int unsigned DEPTH = 2 ** TAG_W;

    rt_state_e state_q, state_d;

    logic             go_up, any_en, reject, accept;
    logic [RADIX-1:0] dn_mask;
    logic [DIG_W-1:0] up_sel;
    logic [NPORT-1:0] mask_now;
    logic [DEPTH-1:0] tag_busy;
    logic             ack_take;
    logic             m_cvld, m_cok;
    logic [PORT_W-1:0] m_cport;
    logic [TAG_W-1:0]  m_ctag;

    logic [NPORT-1:0]  h_mask;
    logic [TAG_W-1:0]  h_tag;
    logic [PORT_W-1:0] h_port;

    ft_route_decide #(
        .RADIX(RADIX), .LEVELS(LEVELS), .LVL(LVL),
        .DIG_W(DIG_W), .ADDR_W(ADDR_W), .PREFIX(PREFIX)
    ) u_decide (
        .dest(hdr_dest), .lo(hdr_lo), .hi(hdr_hi), .bcast(hdr_bcast),
        .go_up(go_up), .dn_mask(dn_mask)
    );

    ft_up_select #(.RADIX(RADIX), .CNT_W(CNT_W), .DIG_W(DIG_W)) u_upsel (
        .clk(clk), .rst_n(rst_n), .up_en(up_en),
        .inc(accept && go_up && !reject), .inc_idx(up_sel),
        .dec(ack_take && (ack_port >= PORT_W'(RADIX))),
        .dec_idx(DIG_W'(ack_port - PORT_W'(RADIX))),
        .sel(up_sel), .any_en(any_en)
    );

    ft_ack_merge #(.NPORT(NPORT), .TAG_W(TAG_W), .PORT_W(PORT_W)) u_merge (
        .clk(clk), .rst_n(rst_n),
        .alloc(accept && !reject), .alloc_tag(hdr_tag),
        .alloc_port(hdr_port), .alloc_mask(mask_now),
        .ack_vld(ack_vld), .ack_port(ack_port), .ack_tag(ack_tag), .ack_ok(ack_ok),
        .tag_busy(tag_busy), .ack_take(ack_take),
        .cack_vld(m_cvld), .cack_port(m_cport), .cack_ok(m_cok), .cack_tag(m_ctag)
    );

    always_comb begin
        mask_now = '0;
        if (go_up) begin
            if (any_en)
                mask_now[RADIX + int'(up_sel)] = 1'b1;
        end else begin
            mask_now[RADIX-1:0] = dn_mask;
        end
    end

    assign reject  = go_up && !any_en;
    assign hdr_rdy = (state_q == S_IDLE) && !ack_vld && !tag_busy[hdr_tag];
    assign accept  = hdr_vld && hdr_rdy;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (accept) state_d = reject ? S_REJ : S_FWD;
            S_FWD:   state_d = S_IDLE;
            S_REJ:   state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register and held header
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            h_mask  <= '0;
            h_tag   <= '0;
            h_port  <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                h_mask <= mask_now;
                h_tag  <= hdr_tag;
                h_port <= hdr_port;
            end
        end
    end

    // outputs
    always_comb begin
        out_vld   = 1'b0;
        out_mask  = '0;
        out_tag   = h_tag;
        cack_vld  = m_cvld;
        cack_port = m_cport;
        cack_ok   = m_cok;
        cack_tag  = m_ctag;
        unique case (state_q)
            S_FWD: begin
                out_vld  = 1'b1;
                out_mask = h_mask;
            end
            S_REJ: begin
                cack_vld  = 1'b1;
                cack_port = h_port;
                cack_ok   = 1'b0;
                cack_tag  = h_tag;
            end
            default: ;
        endcase
    end

    // R1: a forward always names at least one port
    assert_fwd_nonempty_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> (out_mask != '0));
    // R2: an upward forward names exactly one port
    assert_one_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && (out_mask[NPORT-1:RADIX] != '0)) |-> ($countones(out_mask) == 1));
    // R5: unroutable header answers with a failure and no forward
    assert_reject_fail_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && reject) |=> (cack_vld && !cack_ok && !out_vld));
    // R9: no header accepted while an acknowledge arrives
    assert_rdy_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ack_vld |-> !hdr_rdy);
endmodule

// File: tb/fat_tree_router_bench.sv
`timescale 1ns/1ps
module fat_tree_router_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hdr_vld = 1'b0, hdr_bcast = 1'b0;
    logic       hdr_rdy;
    logic [2:0] hdr_port = '0, hdr_tag = '0;
    logic [5:0] hdr_dest = '0, hdr_lo = '0, hdr_hi = '0;
    logic [3:0] up_en = 4'hF;
    logic       out_vld;
    logic [7:0] out_mask;
    logic [2:0] out_tag;
    logic       ack_vld = 1'b0, ack_ok = 1'b0;
    logic [2:0] ack_port = '0, ack_tag = '0;
    logic       cack_vld, cack_ok;
    logic [2:0] cack_port, cack_tag;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    fat_tree_router u_fat_tree_router (
        .clk(clk), .rst_n(rst_n),
        .hdr_vld(hdr_vld), .hdr_rdy(hdr_rdy), .hdr_port(hdr_port),
        .hdr_dest(hdr_dest), .hdr_lo(hdr_lo), .hdr_hi(hdr_hi),
        .hdr_bcast(hdr_bcast), .hdr_tag(hdr_tag), .up_en(up_en),
        .out_vld(out_vld), .out_mask(out_mask), .out_tag(out_tag),
        .ack_vld(ack_vld), .ack_port(ack_port), .ack_tag(ack_tag), .ack_ok(ack_ok),
        .cack_vld(cack_vld), .cack_port(cack_port), .cack_ok(cack_ok), .cack_tag(cack_tag)
    );

    typedef struct packed {
        logic [2:0] port;
        logic [5:0] dest;
        logic [5:0] lo;
        logic [5:0] hi;
        logic       bc;
        logic [3:0] en;
        logic [7:0] mask;
        logic       rej;
    } vec_t;

    // element: level 1, subtree prefix digit 2 (addresses 32..47)
    localparam vec_t VEC [0:8] = '{
        '{3'd5, 6'd39, 6'd0,  6'd0,  1'b0, 4'hF, 8'h02, 1'b0}, // R1 digit 1
        '{3'd0, 6'd44, 6'd0,  6'd0,  1'b0, 4'hF, 8'h08, 1'b0}, // R1 digit 3
        '{3'd2, 6'd16, 6'd0,  6'd0,  1'b0, 4'hF, 8'h10, 1'b0}, // R2 up, link 0
        '{3'd2, 6'd16, 6'd0,  6'd0,  1'b0, 4'hC, 8'h40, 1'b0}, // R4 links 0,1 off
        '{3'd2, 6'd16, 6'd0,  6'd0,  1'b0, 4'h0, 8'h00, 1'b1}, // R5 none enabled
        '{3'd6, 6'd0,  6'd33, 6'd46, 1'b1, 4'hF, 8'h0F, 1'b0}, // R6 full range
        '{3'd6, 6'd0,  6'd36, 6'd41, 1'b1, 4'hF, 8'h06, 1'b0}, // R6 partial
        '{3'd1, 6'd0,  6'd40, 6'd60, 1'b1, 4'hF, 8'h10, 1'b0}, // R6 climbs
        '{3'd3, 6'd0,  6'd20, 6'd40, 1'b1, 4'h0, 8'h00, 1'b1}  // R5 bcast, none enabled
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // drive a header; returns at the negedge after acceptance (decision visible)
    task automatic send_hdr(input logic [2:0] port, input logic [5:0] dest,
                            input logic [5:0] lo, input logic [5:0] hi,
                            input logic bc, input logic [2:0] tag, input logic [3:0] en);
        @(negedge clk);
        hdr_port = port; hdr_dest = dest; hdr_lo = lo; hdr_hi = hi;
        hdr_bcast = bc; hdr_tag = tag; up_en = en; hdr_vld = 1'b1;
        #1;
        while (!hdr_rdy) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        hdr_vld = 1'b0;
    endtask

    // drive one acknowledge; returns at the negedge where its result is visible
    task automatic send_ack(input logic [2:0] port, input logic [2:0] tag, input logic ok);
        @(negedge clk);
        ack_port = port; ack_tag = tag; ack_ok = ok; ack_vld = 1'b1;
        @(negedge clk);
        ack_vld = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R10", "hdr_rdy after reset", hdr_rdy, 1);
        chk("R10", "out_vld after reset", out_vld, 0);
        chk("R10", "cack_vld after reset", cack_vld, 0);

        // table walk
        for (int i = 0; i < 9; i++) begin
            automatic vec_t v = VEC[i];
            automatic logic [2:0] t = 3'(i);
            automatic int last = -1;
            send_hdr(v.port, v.dest, v.lo, v.hi, v.bc, t, v.en);
            if (v.rej) begin
                chk("R5", $sformatf("vec%0d out_vld", i), out_vld, 0);
                chk("R5", $sformatf("vec%0d cack_vld", i), cack_vld, 1);
                chk("R5", $sformatf("vec%0d cack_ok", i), cack_ok, 0);
                chk("R5", $sformatf("vec%0d cack_port", i), cack_port, v.port);
                chk("R5", $sformatf("vec%0d cack_tag", i), cack_tag, t);
            end else begin
                chk("R1 R2 R6", $sformatf("vec%0d out_vld", i), out_vld, 1);
                chk("R1 R2 R6", $sformatf("vec%0d out_mask", i), out_mask, v.mask);
                chk("R1 R2 R6", $sformatf("vec%0d out_tag", i), out_tag, t);
                for (int p = 0; p < 8; p++) if (v.mask[p]) last = p;
                for (int p = 0; p < 8; p++) begin
                    if (v.mask[p]) begin
                        send_ack(3'(p), t, 1'b1);
                        if (p == last) begin
                            chk("R7", $sformatf("vec%0d cack_vld", i), cack_vld, 1);
                            chk("R7", $sformatf("vec%0d cack_ok", i), cack_ok, 1);
                            chk("R7", $sformatf("vec%0d cack_port", i), cack_port, v.port);
                        end else begin
                            chk("R7", $sformatf("vec%0d early cack", i), cack_vld, 0);
                        end
                    end
                end
            end
        end

        // R3: load balancing across up links
        send_hdr(3'd0, 6'd16, 6'd0, 6'd0, 1'b0, 3'd1, 4'hF);
        chk("R3", "first up pick", out_mask, 8'h10);
        send_hdr(3'd0, 6'd16, 6'd0, 6'd0, 1'b0, 3'd2, 4'hF);
        chk("R3", "second up pick", out_mask, 8'h20);
        send_hdr(3'd0, 6'd16, 6'd0, 6'd0, 1'b0, 3'd3, 4'hF);
        chk("R3", "third up pick", out_mask, 8'h40);
        send_ack(3'd4, 3'd1, 1'b1);
        chk("R7", "unicast up cack", cack_vld, 1);
        send_hdr(3'd0, 6'd16, 6'd0, 6'd0, 1'b0, 3'd4, 4'hF);
        chk("R3", "tie goes to lowest link", out_mask, 8'h10);
        send_hdr(3'd0, 6'd16, 6'd0, 6'd0, 1'b0, 3'd5, 4'hF);
        chk("R3", "least loaded link 3", out_mask, 8'h80);
        send_hdr(3'd0, 6'd16, 6'd0, 6'd0, 1'b0, 3'd6, 4'h6);
        chk("R4", "only links 1,2 enabled", out_mask, 8'h20);

        // R9: busy tag blocks header
        @(negedge clk);
        hdr_tag = 3'd2; hdr_dest = 6'd39; hdr_bcast = 1'b0; up_en = 4'hF; hdr_vld = 1'b1;
        #1;
        chk("R9", "hdr_rdy with busy tag", hdr_rdy, 0);
        hdr_vld = 1'b0;

        send_ack(3'd4, 3'd4, 1'b1);
        send_ack(3'd5, 3'd2, 1'b1);
        send_ack(3'd6, 3'd3, 1'b1);
        send_ack(3'd7, 3'd5, 1'b1);
        send_ack(3'd5, 3'd6, 1'b1);
        chk("R7", "last cleanup cack_tag", cack_tag, 6);

        // R7: broadcast with one failing copy
        send_hdr(3'd5, 6'd0, 6'd33, 6'd46, 1'b1, 3'd0, 4'hF);
        chk("R6", "bcast full mask", out_mask, 8'h0F);
        send_ack(3'd0, 3'd0, 1'b1);
        chk("R7", "bcast after 1 of 4", cack_vld, 0);
        send_ack(3'd1, 3'd0, 1'b0);
        chk("R7", "bcast after failing copy", cack_vld, 0);
        send_ack(3'd2, 3'd0, 1'b1);
        send_ack(3'd3, 3'd0, 1'b1);
        chk("R7", "bcast merged cack_vld", cack_vld, 1);
        chk("R7", "bcast merged cack_ok", cack_ok, 0);
        chk("R7", "bcast merged cack_port", cack_port, 5);

        // R8: stray and duplicate acknowledges
        send_hdr(3'd3, 6'd39, 6'd0, 6'd0, 1'b0, 3'd1, 4'hF);
        chk("R1", "unicast down mask", out_mask, 8'h02);
        send_ack(3'd2, 3'd1, 1'b0);
        chk("R8", "ack on non-pending port", cack_vld, 0);
        send_ack(3'd1, 3'd1, 1'b1);
        chk("R8", "entry unharmed by stray ack", cack_ok, 1);
        chk("R7", "unicast cack_port", cack_port, 3);
        send_ack(3'd1, 3'd1, 1'b0);
        chk("R8", "ack on freed tag", cack_vld, 0);

        // R9: header blocked while an acknowledge arrives
        @(negedge clk);
        hdr_tag = 3'd7; hdr_dest = 6'd39; hdr_vld = 1'b1;
        ack_vld = 1'b1; ack_port = 3'd0; ack_tag = 3'd7; ack_ok = 1'b1;
        #1;
        chk("R9", "hdr_rdy with ack_vld", hdr_rdy, 0);
        hdr_vld = 1'b0;
        @(negedge clk);
        ack_vld = 1'b0;
        chk("R8", "ack with no entry", cack_vld, 0);
        chk("R9", "no forward from blocked header", out_vld, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule